// File: doc/BRIEF.md
# Dual-Rate Circular Buffer Address Controller

This block drives the address and control side of a circular sample store that is written at one rate and read at another. A write pointer steps once per rising edge of a write-clock level that is already synchronous to the system clock. A read pointer steps once per transition of a toggle line that comes from a separate, variable-rate read clock domain. That toggle line passes through a synchronizer, so both pointers live entirely on the system clock. Both pointers wrap to zero at a buffer length picked by a three-bit selector. The choices are 256, 512, and so on in steps of 256, up to 2048 locations.

The store has a single address bus, and the two pointers share it by time multiplexing. While the write-clock level is low, the bus carries the write pointer and the cycle is a write slot. While it is high, the bus carries the read pointer. Setting the fixed-delay mode ties the bus to the write pointer in both phases, so a location is read just before it is overwritten. The two top address bits select one of four bank enables. The write strobe is held back for a settling interval at the start of every write slot. A freeze input blocks writes while both pointers keep running, so the stored passage plays back in a loop.

Top module: `dly_addr_ctrl`

## Requirements
- R1: While reset is held, and once it is released, `wr_ptr`, `rd_ptr` and `mem_addr` are 0, `mem_we` is 0 and `bank_cs` is 4'b0001.
- R2: `wr_ptr` increases by one at the first clock edge that samples `wclk_lvl` high after a sample of it low. The new value is visible after that edge.
- R3: With `len_sel` = s, the buffer length is 256*(s+1). A pointer that steps from the value 256*(s+1)-1 goes to 0.
- R4: Each change of level on `rd_tgl` advances `rd_ptr` by exactly one. The new value appears after the third clock edge that follows the change, and not before it.
- R5: `rd_ptr` wraps at the same selected length as `wr_ptr`.
- R6: With `delay_mode` = 0, `mem_addr` equals `wr_ptr` when the most recent edge sampled `wclk_lvl` low (write slot). Otherwise it equals `rd_ptr` (read slot).
- R7: With `delay_mode` = 1, `mem_addr` equals `wr_ptr` in both slots.
- R8: `bank_cs` is one-hot. Bit k is set where k = `mem_addr[10:9]`.
- R9: `mem_we` rises after the fourth consecutive edge that samples `wclk_lvl` low, stays high for the rest of the write slot, and falls after the first edge that samples `wclk_lvl` high.
- R10: While `freeze` is 1, `mem_we` stays 0. Both pointers keep stepping as in R2 and R4.
- R11: When `len_sel` is lowered below the current pointer value, that pointer's next step takes it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wclk_lvl | input | 1 | Write-clock level, synchronous to clk; low = write slot |
| rd_tgl | input | 1 | Read-clock toggle from a foreign domain; each change is one read step |
| len_sel | input | 3 | Buffer length select, length = 256*(len_sel+1) |
| delay_mode | input | 1 | 1 = bus always carries the write pointer |
| freeze | input | 1 | 1 = block writes, keep replaying the store |
| mem_addr | output | 11 | Address for the sample store |
| bank_cs | output | 4 | One-hot bank enable from mem_addr[10:9] |
| mem_we | output | 1 | Delayed write strobe |
| wr_ptr | output | 11 | Current write pointer |
| rd_ptr | output | 11 | Current read pointer |

## Verification
A write step shows on `wr_ptr` one edge after `wclk_lvl` is driven high, and the bus switches slots on that same edge. A read toggle shows on `rd_ptr` only after the third edge, and the bench reads the pointer after the second edge as well to prove it has not moved early. The strobe is expected low for the first three edges of each write slot and high from the fourth. Every comparison is made at the falling clock edge after the counted number of rising edges, while inputs are changed only at falling edges. Random slot lengths, random selector values and random freeze and mode settings are applied at slot boundaries, with directed runs for pointer wrap and for shortening the buffer.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int unsigned ADDR_W     = 11;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned MIN_LOG2   = 8;
  localparam int unsigned BANK_W     = 2;
  localparam int unsigned SETTLE_CYC = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    SLOT_WRITE = 1'b0,
    SLOT_READ  = 1'b1
  } slot_e;
endpackage

// File: rtl/dly_wrap_ctr.sv
module dly_wrap_ctr #(
  parameter int unsigned AW       = 11,
  parameter int unsigned SW       = 3,
  parameter int unsigned MIN_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [SW-1:0] len_sel,
  output logic [AW-1:0] ptr
);
  localparam int unsigned LW = AW + 1;

  logic [LW-1:0] len_w;
  logic [LW-1:0] last_w;
  logic          at_end;
  logic [AW-1:0] ptr_n;

  always_comb begin
    len_w  = (LW'(len_sel) + LW'(1)) << MIN_LOG2;
    last_w = len_w - LW'(1);
    at_end = ({1'b0, ptr} >= last_w);
    ptr_n  = ptr;
    if (step) begin
      ptr_n = at_end ? '0 : ptr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= ptr_n;
    end
  end
endmodule

// File: rtl/dly_tgl_sync.sv
module dly_tgl_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [DEPTH:0] chain;
  logic [DEPTH:0] chain_n;

  always_comb begin
    chain_n[0] = tgl_in;
  end

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_comb begin
      chain_n[i] = chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= chain_n;
    end
  end

  assign pulse = chain[DEPTH] ^ chain[DEPTH-1];
endmodule

// File: rtl/dly_we_gen.sv
module dly_we_gen
  import dly_pkg::*;
#(
  parameter int unsigned SETTLE = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wclk_lvl,
  input  logic  freeze,
  output slot_e slot,
  output logic  wr_step,
  output logic  mem_we
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE);

  logic          wclk_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (wclk_lvl) begin
      cnt_n = '0;
    end else if (cnt != CMAX) begin
      cnt_n = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q <= 1'b1;
      cnt    <= '0;
    end else begin
      wclk_q <= wclk_lvl;
      cnt    <= cnt_n;
    end
  end

  assign slot    = wclk_q ? SLOT_READ : SLOT_WRITE;
  assign wr_step = wclk_lvl & ~wclk_q;
  assign mem_we  = (slot == SLOT_WRITE) & (cnt == CMAX) & ~freeze;
endmodule

// File: rtl/dly_bank_dec.sv
module dly_bank_dec #(
  parameter int unsigned BW = 2
) (
  input  logic [BW-1:0]      sel,
  output logic [(1<<BW)-1:0] cs
);
  localparam int unsigned NB = 1 << BW;

  for (genvar b = 0; b < NB; b++) begin : g_cs
    assign cs[b] = (sel == BW'(b));
  end
endmodule

// File: rtl/dly_addr_ctrl.sv
module dly_addr_ctrl
  import dly_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wclk_lvl,
  input  logic                 rd_tgl,
  input  logic [SEL_W-1:0]     len_sel,
  input  logic                 delay_mode,
  input  logic                 freeze,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [(1<<BANK_W)-1:0] bank_cs,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    wr_ptr,
  output logic [ADDR_W-1:0]    rd_ptr
);
  logic  rst_s1, rst_sn;
  slot_e slot;
  logic  wr_step;
  logic  rd_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  dly_we_gen #(.SETTLE(SETTLE_CYC)) u_we (
    .clk(clk), .rst_n(rst_sn), .wclk_lvl(wclk_lvl), .freeze(freeze),
    .slot(slot), .wr_step(wr_step), .mem_we(mem_we)
  );

  dly_tgl_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_sn), .tgl_in(rd_tgl), .pulse(rd_step)
  );

  dly_wrap_ctr #(.AW(ADDR_W), .SW(SEL_W), .MIN_LOG2(MIN_LOG2)) u_wr_ctr (
    .clk(clk), .rst_n(rst_sn), .step(wr_step), .len_sel(len_sel), .ptr(wr_ptr)
  );

  dly_wrap_ctr #(.AW(ADDR_W), .SW(SEL_W), .MIN_LOG2(MIN_LOG2)) u_rd_ctr (
    .clk(clk), .rst_n(rst_sn), .step(rd_step), .len_sel(len_sel), .ptr(rd_ptr)
  );

  always_comb begin
    if (delay_mode || (slot == SLOT_WRITE)) begin
      mem_addr = wr_ptr;
    end else begin
      mem_addr = rd_ptr;
    end
  end

  dly_bank_dec #(.BW(BANK_W)) u_bank (
    .sel(mem_addr[ADDR_W-1 -: BANK_W]), .cs(bank_cs)
  );
endmodule

// File: rtl/dly_addr_ctrl_chk.sv
module dly_addr_ctrl_chk
  import dly_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wclk_lvl,
  input logic                   delay_mode,
  input logic                   freeze,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic [(1<<BANK_W)-1:0] bank_cs,
  input logic                   mem_we,
  input logic [ADDR_W-1:0]      wr_ptr,
  input logic [ADDR_W-1:0]      rd_ptr
);
  assert_bank_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bank_cs) == 1) && bank_cs[mem_addr[ADDR_W-1 -: BANK_W]]);

  assert_delay_wr_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    delay_mode |-> (mem_addr == wr_ptr));

  assert_freeze_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !mem_we);

  assert_we_in_write_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(!wclk_lvl));

  assert_wr_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr != $past(wr_ptr)) |-> ((wr_ptr == '0) || (wr_ptr == $past(wr_ptr) + ADDR_W'(1))));

  assert_rd_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> ((rd_ptr == '0) || (rd_ptr == $past(rd_ptr) + ADDR_W'(1))));
endmodule

bind dly_addr_ctrl dly_addr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wclk_lvl(wclk_lvl), .delay_mode(delay_mode),
  .freeze(freeze), .mem_addr(mem_addr), .bank_cs(bank_cs), .mem_we(mem_we),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/dly_addr_ctrl_tb.sv
module dly_addr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wclk_lvl, rd_tgl, delay_mode, freeze;
  logic [2:0]  len_sel;
  logic [10:0] mem_addr, wr_ptr, rd_ptr;
  logic [3:0]  bank_cs;
  logic        mem_we;

  int n_run = 0;
  int n_fail = 0;
  int exp_wr = 0;
  int exp_rd = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dly_addr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wclk_lvl(wclk_lvl), .rd_tgl(rd_tgl),
    .len_sel(len_sel), .delay_mode(delay_mode), .freeze(freeze),
    .mem_addr(mem_addr), .bank_cs(bank_cs), .mem_we(mem_we),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  function automatic int nxt(int p, int s);
    return (p >= 256 * (s + 1) - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(int act, int exp, string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    finish_run();
  end

  task automatic chk_addr(string req);
    chk(int'(bank_cs), 1 << mem_addr[10:9], "R8 bank enable");
    chk(int'(mem_addr), (delay_mode || !wclk_lvl) ? exp_wr : exp_rd, req);
  endtask

  // One write slot of lowc edges, then a read slot of highc edges (highc >= 3 when do_rd)
  task automatic wcycle(int lowc, int highc, bit do_rd);
    wclk_lvl = 1'b0;
    for (int k = 1; k <= lowc; k++) begin
      @(posedge clk); @(negedge clk);
      chk(int'(mem_we), (k >= 4 && !freeze) ? 1 : 0, freeze ? "R10 freeze" : "R9 strobe delay");
      chk_addr(delay_mode ? "R7 delay addr" : "R6 write slot addr");
    end
    wclk_lvl = 1'b1;
    if (do_rd) rd_tgl = ~rd_tgl;
    for (int k = 1; k <= highc; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 1) begin
        exp_wr = nxt(exp_wr, len_sel);
        chk(int'(wr_ptr), exp_wr, "R2 R3 write step");
        chk(int'(mem_we), 0, "R9 strobe drop");
      end
      if (do_rd && k == 2) chk(int'(rd_ptr), exp_rd, "R4 no early read step");
      if (do_rd && k == 3) begin
        exp_rd = nxt(exp_rd, len_sel);
        chk(int'(rd_ptr), exp_rd, "R4 R5 read step");
      end
      chk_addr(delay_mode ? "R7 delay addr" : "R6 read slot addr");
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wclk_lvl = 1'b1; rd_tgl = 1'b0;
    len_sel = 3'd0; delay_mode = 1'b0; freeze = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(wr_ptr), 0, "R1 reset wr_ptr");
    chk(int'(mem_we), 0, "R1 reset mem_we");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(wr_ptr), 0, "R1 wr_ptr");
    chk(int'(rd_ptr), 0, "R1 rd_ptr");
    chk(int'(mem_addr), 0, "R1 mem_addr");
    chk(int'(bank_cs), 1, "R1 bank_cs");
    chk(int'(mem_we), 0, "R1 mem_we");

    // R3 R5: shortest length, both pointers wrap
    for (int i = 0; i < 300; i++) wcycle(4 + $urandom_range(0, 3), 3 + $urandom_range(0, 2), 1'b1);

    // R9: short write slots never raise the strobe
    for (int i = 0; i < 4; i++) wcycle(3, 1, 1'b0);

    // long buffer, reach upper banks
    len_sel = 3'd7;
    for (int i = 0; i < 1200; i++) wcycle(4, $urandom_range(1, 3), 1'b0);
    chk(int'(wr_ptr) > 511 ? 1 : 0, 1, "R11 setup");
    // R11: shorten below current pointer
    len_sel = 3'd1;
    wcycle(4, 3, 1'b1);
    chk(int'(wr_ptr), 0, "R11 wr shrink wrap");

    // R10: freeze, pointers keep moving
    freeze = 1'b1;
    for (int i = 0; i < 20; i++) wcycle(6, 3, 1'b1);
    freeze = 1'b0;

    // R7: delay mode directed
    delay_mode = 1'b1;
    for (int i = 0; i < 20; i++) wcycle(5, 4, 1'b1);
    delay_mode = 1'b0;

    // mixed random
    for (int i = 0; i < 500; i++) begin
      if ($urandom_range(0, 15) == 0) len_sel = 3'($urandom_range(0, 7));
      delay_mode = ($urandom_range(0, 3) == 0);
      freeze     = ($urandom_range(0, 4) == 0);
      wcycle($urandom_range(1, 8), 3 + $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule